// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block resolves one instruction operand. A decoder presents a mode code together with the base and index register values, a 16-bit literal/displacement field, a scale selector, an access size and the index of the base register, and pulses `start`. The unit then returns one of two things: a plain operand value (for register and literal modes) or a final memory address (for every other mode). Post-increment and post-decrement modes also issue a one-cycle request to write the updated base register back.

Memory-indirect mode needs a pointer fetch. The unit raises a read request on a simple request/valid port, waits as long as memory takes, and returns the fetched word as the address. Mode codes outside the defined set are flagged as illegal. An illegal mode causes no memory traffic and no register update. The unit handles one operand at a time and ignores new work while it is busy.

Top module: `eau_top`

## Requirements
- R1: Mode code 0 returns the base register value and mode code 1 returns the literal sign-extended to 32 bits. Both return it as an operand (`resultIsAddr`=0) and make no memory request.
- R2: Mode codes 2 to 5 return an address (`resultIsAddr`=1): code 2 gives the sign-extended literal, code 3 gives the base, code 4 gives base + sign-extended literal, and code 5 gives base + index. All sums wrap modulo 2^32.
- R3: Mode code 6 returns base + (index << scaleSel) + sign-extended literal, where scaleSel 0..3 gives a factor of 1, 2, 4 or 8.
- R4: Mode codes 7 (post-increment) and 8 (post-decrement) return the unmodified base as the address. The written-back value is base + step or base - step, with step 1, 2 or 4 for accSize 0, 1, and 2 or 3.
- R5: `wbValid` is high only in the `done` cycle of modes 7 and 8. At that point `wbIdx` equals the `baseIdx` captured at start.
- R6: For every mode except 9, `done` is a one-cycle pulse in the cycle after the accepted start.
- R7: `busy` is high from the cycle after an accepted start up to and including the `done` cycle. A start that arrives while busy has no effect.
- R8: For mode code 9, `memReq` is high with `memAddr` equal to the base from the cycle after start until `memValid` is sampled. `done` follows one cycle later with `result` equal to the fetched `memData` and `resultIsAddr`=1. `memValid` is ignored when no request is outstanding.
- R9: Mode codes 10 to 15 raise `illegalMode` together with `done`, with `result`=0 and `resultIsAddr`=0. They produce no `memReq` and no `wbValid`.
- R10: After reset, `done`, `busy`, `memReq`, `wbValid` and `illegalMode` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving one operand |
| mode | input | 4 | Addressing mode code |
| baseVal | input | 32 | Base register value |
| idxVal | input | 32 | Index register value |
| litField | input | 16 | Literal or displacement field |
| scaleSel | input | 2 | Index shift amount (0..3) |
| accSize | input | 2 | Access size code for the update step |
| baseIdx | input | 5 | Register number of the base |
| memReq | output | 1 | Pointer read request |
| memAddr | output | 32 | Pointer read address |
| memValid | input | 1 | Pointer read data valid |
| memData | input | 32 | Pointer read data |
| done | output | 1 | Result valid pulse |
| busy | output | 1 | Operation in flight |
| result | output | 32 | Operand value or final address |
| resultIsAddr | output | 1 | Result is a memory address |
| illegalMode | output | 1 | Mode code undefined |
| wbValid | output | 1 | Base register write-back request |
| wbIdx | output | 5 | Write-back register number |
| wbData | output | 32 | Write-back value |

## Verification
The hardest situation to reach is a second `start` landing while a memory-indirect fetch is still waiting on memory. The bench holds `memValid` low for several cycles, drives a competing direct-mode start in the middle of the wait, and then checks that the eventual result is the fetched pointer and not the direct operand. Two related cases are driven the same way: a start that arrives exactly in the `done` cycle, and a stray `memValid` pulse while the unit is idle. The bench also uses a zero-wait memory response.

// File: rtl/eau_pkg.sv
package eau_pkg;

  localparam logic [3:0] MODE_REG    = 4'd0;
  localparam logic [3:0] MODE_IMM    = 4'd1;
  localparam logic [3:0] MODE_ABS    = 4'd2;
  localparam logic [3:0] MODE_RIND   = 4'd3;
  localparam logic [3:0] MODE_BDISP  = 4'd4;
  localparam logic [3:0] MODE_BIDX   = 4'd5;
  localparam logic [3:0] MODE_SCALED = 4'd6;
  localparam logic [3:0] MODE_AINC   = 4'd7;
  localparam logic [3:0] MODE_ADEC   = 4'd8;
  localparam logic [3:0] MODE_MIND   = 4'd9;
  localparam logic [3:0] MODE_LAST   = MODE_MIND;

  typedef struct packed {
    logic loadOp;     // start accepted: capture operands and compute
    logic loadFetch;  // pointer word arrived: capture it as the result
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FIN  = 2'd2
  } state_e;

  function automatic logic modeIllegal(input logic [3:0] m);
    return m > MODE_LAST;
  endfunction

  function automatic logic modeUpdates(input logic [3:0] m);
    return (m == MODE_AINC) || (m == MODE_ADEC);
  endfunction

  function automatic logic modeIndirect(input logic [3:0] m);
    return m == MODE_MIND;
  endfunction

endpackage

// File: rtl/eau_ctrl.sv
module eau_ctrl
  import eau_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] mode,
  input  logic       memValid,
  output strobe_t    strb,
  output logic       busy,
  output logic       done,
  output logic       memReq,
  output logic       wbValid,
  output logic       illegalMode
);

  state_e stateQ, stateD;
  logic   wbPendQ;
  logic   illPendQ;
  logic   accept;

  assign accept = (stateQ == ST_IDLE) && start;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (start) stateD = modeIndirect(mode) ? ST_WAIT : ST_FIN;
      ST_WAIT: if (memValid) stateD = ST_FIN;
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ   <= ST_IDLE;
      wbPendQ  <= 1'b0;
      illPendQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) begin
        wbPendQ  <= modeUpdates(mode);
        illPendQ <= modeIllegal(mode);
      end
    end
  end

  assign strb.loadOp    = accept;
  assign strb.loadFetch = (stateQ == ST_WAIT) && memValid;

  assign busy        = (stateQ != ST_IDLE);
  assign done        = (stateQ == ST_FIN);
  assign memReq      = (stateQ == ST_WAIT);
  assign wbValid     = done && wbPendQ;
  assign illegalMode = done && illPendQ;

  // R8: a request only exists while the unit is busy
  a_r8_req_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> busy);

  // R8: the request holds until memory answers
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memValid) |=> memReq);

  // R6: done never lasts two cycles
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: busy only falls right after a done cycle
  a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  // R5: write-back is confined to a legal done cycle
  a_r5_wb_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> (done && !illegalMode));

  // R9: an illegal mode never starts a pointer fetch
  a_r9_illegal_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && modeIllegal(mode)) |=> !memReq);

endmodule

// File: rtl/eau_dp.sv
module eau_dp
  import eau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIT_W  = 16,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic [LIT_W-1:0]  litField,
  input  logic [1:0]        scaleSel,
  input  logic [1:0]        accSize,
  input  logic [RIDX_W-1:0] baseIdx,
  input  logic [ADDR_W-1:0] memData,
  output logic [ADDR_W-1:0] result,
  output logic              resultIsAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [RIDX_W-1:0] wbIdx,
  output logic [ADDR_W-1:0] wbData
);

  localparam int EXT_W = (ADDR_W > LIT_W) ? ADDR_W - LIT_W : 1;

  logic [ADDR_W-1:0] litExt;
  logic [ADDR_W-1:0] idxScaled;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] resNext;
  logic              isAddrNext;
  logic [ADDR_W-1:0] wbNext;

  generate
    if (ADDR_W > LIT_W) begin : g_ext
      assign litExt = {{EXT_W{litField[LIT_W-1]}}, litField};
    end else begin : g_trunc
      assign litExt = litField[ADDR_W-1:0];
    end
  endgenerate

  assign idxScaled = idxVal << scaleSel;

  always_comb begin
    unique case (accSize)
      2'd0:    stepVal = ADDR_W'(1);
      2'd1:    stepVal = ADDR_W'(2);
      default: stepVal = ADDR_W'(4);
    endcase
  end

  always_comb begin
    resNext    = '0;
    isAddrNext = 1'b1;
    wbNext     = baseVal;
    unique case (mode)
      MODE_REG:    begin resNext = baseVal; isAddrNext = 1'b0; end
      MODE_IMM:    begin resNext = litExt;  isAddrNext = 1'b0; end
      MODE_ABS:    resNext = litExt;
      MODE_RIND:   resNext = baseVal;
      MODE_BDISP:  resNext = baseVal + litExt;
      MODE_BIDX:   resNext = baseVal + idxVal;
      MODE_SCALED: resNext = baseVal + idxScaled + litExt;
      MODE_AINC:   begin resNext = baseVal; wbNext = baseVal + stepVal; end
      MODE_ADEC:   begin resNext = baseVal; wbNext = baseVal - stepVal; end
      MODE_MIND:   resNext = '0;
      default:     begin resNext = '0; isAddrNext = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      resultIsAddr <= 1'b0;
      memAddr      <= '0;
      wbIdx        <= '0;
      wbData       <= '0;
    end else if (strb.loadOp) begin
      result       <= resNext;
      resultIsAddr <= isAddrNext;
      memAddr      <= baseVal;
      wbIdx        <= baseIdx;
      wbData       <= wbNext;
    end else if (strb.loadFetch) begin
      result       <= memData;
      resultIsAddr <= 1'b1;
    end
  end

  // R8: the pointer address never moves while a fetch is pending
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.loadOp) |=> $stable(memAddr));

endmodule

// File: rtl/eau_top.sv
module eau_top
  import eau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIT_W  = 16,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic [LIT_W-1:0]  litField,
  input  logic [1:0]        scaleSel,
  input  logic [1:0]        accSize,
  input  logic [RIDX_W-1:0] baseIdx,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [ADDR_W-1:0] memData,
  output logic              done,
  output logic              busy,
  output logic [ADDR_W-1:0] result,
  output logic              resultIsAddr,
  output logic              illegalMode,
  output logic              wbValid,
  output logic [RIDX_W-1:0] wbIdx,
  output logic [ADDR_W-1:0] wbData
);

  strobe_t strb;

  eau_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode        (mode),
    .memValid    (memValid),
    .strb        (strb),
    .busy        (busy),
    .done        (done),
    .memReq      (memReq),
    .wbValid     (wbValid),
    .illegalMode (illegalMode)
  );

  eau_dp #(
    .ADDR_W (ADDR_W),
    .LIT_W  (LIT_W),
    .RIDX_W (RIDX_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .mode         (mode),
    .baseVal      (baseVal),
    .idxVal       (idxVal),
    .litField     (litField),
    .scaleSel     (scaleSel),
    .accSize      (accSize),
    .baseIdx      (baseIdx),
    .memData      (memData),
    .result       (result),
    .resultIsAddr (resultIsAddr),
    .memAddr      (memAddr),
    .wbIdx        (wbIdx),
    .wbData       (wbData)
  );

  // R9: an illegal result is never labelled as an address
  a_r9_illegal_not_addr: assert property (@(posedge clk) disable iff (!rst_n)
    illegalMode |-> (!resultIsAddr && result == '0));

  // R8: the request address stays put while memory is answering
  a_r8_port_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memValid) |=> $stable(memAddr));

endmodule

// File: tb/tb_eau_top.sv
module tb_eau_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [31:0] baseVal = '0;
  logic [31:0] idxVal = '0;
  logic [15:0] litField = '0;
  logic [1:0]  scaleSel = '0;
  logic [1:0]  accSize = '0;
  logic [4:0]  baseIdx = '0;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        memReq, done, busy, resultIsAddr, illegalMode, wbValid;
  logic [31:0] memAddr, result, wbData;
  logic [4:0]  wbIdx;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eau_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .baseVal(baseVal), .idxVal(idxVal), .litField(litField),
    .scaleSel(scaleSel), .accSize(accSize), .baseIdx(baseIdx),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .done(done), .busy(busy), .result(result), .resultIsAddr(resultIsAddr),
    .illegalMode(illegalMode), .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData)
  );

  typedef struct packed {
    logic [3:0]  m;
    logic [31:0] b;
    logic [31:0] x;
    logic [15:0] l;
    logic [1:0]  sc;
    logic [1:0]  sz;
    logic [31:0] expRes;
    logic        expAddr;
    logic        expWb;
    logic [31:0] expWbData;
    logic        expIll;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  32'h12345678, 32'h0,  16'h0,    2'd0, 2'd0, 32'h12345678, 1'b0, 1'b0, 32'h0, 1'b0},
    '{4'd1,  32'h0,        32'h0,  16'hFFF0, 2'd0, 2'd0, 32'hFFFFFFF0, 1'b0, 1'b0, 32'h0, 1'b0},
    '{4'd2,  32'h0,        32'h0,  16'h7FFF, 2'd0, 2'd0, 32'h00007FFF, 1'b1, 1'b0, 32'h0, 1'b0},
    '{4'd3,  32'h00004000, 32'h0,  16'h0,    2'd0, 2'd0, 32'h00004000, 1'b1, 1'b0, 32'h0, 1'b0},
    '{4'd4,  32'h00001000, 32'h0,  16'hFFFC, 2'd0, 2'd0, 32'h00000FFC, 1'b1, 1'b0, 32'h0, 1'b0},
    '{4'd5,  32'h00001000, 32'h20, 16'h0,    2'd0, 2'd0, 32'h00001020, 1'b1, 1'b0, 32'h0, 1'b0},
    '{4'd6,  32'h00001000, 32'h20, 16'h0004, 2'd3, 2'd0, 32'h00001104, 1'b1, 1'b0, 32'h0, 1'b0},
    '{4'd6,  32'h00010000, 32'h20, 16'h8000, 2'd1, 2'd0, 32'h00008040, 1'b1, 1'b0, 32'h0, 1'b0},
    '{4'd7,  32'h00002000, 32'h0,  16'h0,    2'd0, 2'd2, 32'h00002000, 1'b1, 1'b1, 32'h00002004, 1'b0},
    '{4'd7,  32'h00002000, 32'h0,  16'h0,    2'd0, 2'd0, 32'h00002000, 1'b1, 1'b1, 32'h00002001, 1'b0},
    '{4'd8,  32'h00002000, 32'h0,  16'h0,    2'd0, 2'd1, 32'h00002000, 1'b1, 1'b1, 32'h00001FFE, 1'b0},
    '{4'd8,  32'h00000000, 32'h0,  16'h0,    2'd0, 2'd3, 32'h00000000, 1'b1, 1'b1, 32'hFFFFFFFC, 1'b0},
    '{4'd12, 32'h00003000, 32'h4,  16'h10,   2'd2, 2'd2, 32'h00000000, 1'b0, 1'b0, 32'h0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                       input logic [15:0] l, input logic [1:0] sc, input logic [1:0] sz,
                       input logic [4:0] ri);
    @(negedge clk);
    mode = m; baseVal = b; idxVal = x; litField = l; scaleSel = sc; accSize = sz;
    baseIdx = ri; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 done", {31'b0, done}, 32'd0);
    chk("R10 busy", {31'b0, busy}, 32'd0);
    chk("R10 memReq", {31'b0, memReq}, 32'd0);
    chk("R10 wbValid", {31'b0, wbValid}, 32'd0);
    chk("R10 illegalMode", {31'b0, illegalMode}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].m, VECS[i].b, VECS[i].x, VECS[i].l, VECS[i].sc, VECS[i].sz, 5'd7);
      chk($sformatf("R6 done vec%0d", i), {31'b0, done}, 32'd1);
      chk($sformatf("R7 busy vec%0d", i), {31'b0, busy}, 32'd1);
      chk($sformatf("R1/R2/R3/R4 result vec%0d", i), result, VECS[i].expRes);
      chk($sformatf("R1/R2 isAddr vec%0d", i), {31'b0, resultIsAddr}, {31'b0, VECS[i].expAddr});
      chk($sformatf("R5 wbValid vec%0d", i), {31'b0, wbValid}, {31'b0, VECS[i].expWb});
      chk($sformatf("R9 illegal vec%0d", i), {31'b0, illegalMode}, {31'b0, VECS[i].expIll});
      chk($sformatf("R9 noReq vec%0d", i), {31'b0, memReq}, 32'd0);
      if (VECS[i].expWb) begin
        chk($sformatf("R4 wbData vec%0d", i), wbData, VECS[i].expWbData);
        chk($sformatf("R5 wbIdx vec%0d", i), {27'b0, wbIdx}, 32'd7);
      end
      @(negedge clk);
      chk($sformatf("R6 done pulse vec%0d", i), {31'b0, done}, 32'd0);
      chk($sformatf("R7 busy cleared vec%0d", i), {31'b0, busy}, 32'd0);
    end

    // R8: memory-indirect with a three-cycle wait, plus a start while busy (R7)
    issue(4'd9, 32'h0000_8000, 32'h0, 16'h0, 2'd0, 2'd0, 5'd3);
    chk("R8 memReq raised", {31'b0, memReq}, 32'd1);
    chk("R8 memAddr", memAddr, 32'h0000_8000);
    mode = 4'd0; baseVal = 32'hDEAD_BEEF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 start while busy ignored (no done)", {31'b0, done}, 32'd0);
    chk("R8 memReq held", {31'b0, memReq}, 32'd1);
    @(negedge clk);
    chk("R8 still waiting", {31'b0, done}, 32'd0);
    memValid = 1'b1; memData = 32'hCAFE_0040;
    @(negedge clk);
    memValid = 1'b0;
    chk("R8 done after fetch", {31'b0, done}, 32'd1);
    chk("R8 result is fetched word", result, 32'hCAFE_0040);
    chk("R8 isAddr", {31'b0, resultIsAddr}, 32'd1);
    chk("R8 memReq dropped", {31'b0, memReq}, 32'd0);
    chk("R5 no wb for indirect", {31'b0, wbValid}, 32'd0);
    @(negedge clk);
    chk("R7 idle after indirect", {31'b0, busy}, 32'd0);

    // R8: zero-wait memory answer
    issue(4'd9, 32'h0000_0100, 32'h0, 16'h0, 2'd0, 2'd0, 5'd1);
    chk("R8 zero-wait memAddr", memAddr, 32'h0000_0100);
    memValid = 1'b1; memData = 32'h0000_0ABC;
    @(negedge clk);
    memValid = 1'b0;
    chk("R8 zero-wait done", {31'b0, done}, 32'd1);
    chk("R8 zero-wait result", result, 32'h0000_0ABC);
    @(negedge clk);

    // R8: stray memValid while idle does nothing
    memValid = 1'b1; memData = 32'h1111_1111;
    @(negedge clk);
    memValid = 1'b0;
    chk("R8 stray valid no done", {31'b0, done}, 32'd0);
    chk("R8 stray valid no busy", {31'b0, busy}, 32'd0);
    chk("R8 stray valid result kept", result, 32'h0000_0ABC);

    // R7: start presented in the done cycle is ignored
    issue(4'd5, 32'h0000_0010, 32'h0000_0001, 16'h0, 2'd0, 2'd0, 5'd2);
    chk("R6 done before overlap", {31'b0, done}, 32'd1);
    mode = 4'd1; litField = 16'h0055; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 start in done cycle ignored", {31'b0, done}, 32'd0);
    chk("R7 result kept after ignored start", result, 32'h0000_0011);
    chk("R7 idle after ignored start", {31'b0, busy}, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule